// File: doc/BRIEF.md
# Factory Bad-Block Marker Scanner

This block runs once after power-up, or again whenever software requests a fresh pass. It walks every erase block of a NAND array in ascending order and produces a one-bit-per-block table of blocks that left the factory marked as unusable. For each block it issues single-byte reads of the factory marker, which sits at byte 5 of the 16-byte spare area (column 517 of the page). It reads page 0 of the block first and then page 1. Any marker byte other than FFh condemns the block. Block 0 is guaranteed good and is always recorded as valid.

Reads go out on a simple request port. A one-cycle request carries a page address, a spare-area flag and a column offset. The flash side answers, one or more cycles later, with a one-cycle valid and the data byte. Only one read is in flight at a time. When the last block has been judged, a done flag rises and a count of condemned blocks becomes valid. A separate lookup port returns any table entry one clock after its address is presented. A new start request restarts the pass from block 0 at any moment. A read that is still in flight at that moment is allowed to complete, and its byte is thrown away.

Top module: `blk_mark_scan`

## Requirements
- R1: After reset no read request is raised, done_o is 0, bad_count_o is 0 and every table entry reads 0 (valid).
- R2: A high start_i at any clock edge clears every table entry to 0, clears bad_count_o and done_o, and makes the next read target page 0. With no read in flight, rd_req_o rises in the second cycle after that edge.
- R3: Each read request is a one-cycle pulse on rd_req_o with rd_spare_o = 1 and rd_col_o = 5. A new request is never raised before rd_valid_i has answered the previous one, and after a consumed answer the next request follows in the next cycle.
- R4: Blocks are visited in ascending order from 0 to NUM_BLOCKS-1. Within block b, page b*32 is read before page b*32+1.
- R5: When the page-0 byte of a block is not FFh, page 1 of that block is not read, and the next request targets page 0 of the following block.
- R6: A block's entry becomes 1 (bad) when either marker byte read for it differs from FFh, and 0 when both bytes are FFh.
- R7: The entry of block 0 is 0 whatever bytes are read for it.
- R8: In the cycle after the last block has been judged, done_o rises and stays high until the next start. bad_count_o then equals the number of entries set to 1 and holds steady. No request is raised while done_o is high.
- R9: q_bad_o presents the entry at q_addr_i one clock after the address, using the contents from before any write or clear taken at that same edge.
- R10: A start while a read is in flight makes the scanner wait for that read's rd_valid_i and discard its byte. A start in the very cycle that rd_valid_i arrives discards the byte as well. In both cases the pass then begins at page 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin or restart a pass from block 0 |
| rd_req_o | output | 1 | One-cycle byte-read request |
| rd_page_o | output | 17 | Page address of the read |
| rd_spare_o | output | 1 | Read targets the spare area |
| rd_col_o | output | 9 | Byte offset within the selected area |
| rd_valid_i | input | 1 | Read answer valid, one cycle |
| rd_data_i | input | 8 | Byte returned with rd_valid_i |
| done_o | output | 1 | Pass complete, count and table final |
| bad_count_o | output | 13 | Number of blocks marked bad |
| q_addr_i | input | 12 | Block number to look up |
| q_bad_o | output | 1 | Looked-up entry, 1 = bad |

## Verification
Two pairs of functions can collide in one cycle. In the first, a restart lands on the same edge that a read answer is consumed. The bench raises start_i together with rd_valid_i partway through a pass, and later raises it while a slower answer is still pending. Its model then expects the byte to leave no trace in the table or the count, and the first new request to be page 0 at the exact cycle derived from R2 and R10. In the second, the lookup port is aimed at the block being judged throughout each pass, so table writes and clears coincide with reads of the same entry, and every cycle is compared against the model's pre-edge table.

// File: rtl/nbs_pkg.sv
`timescale 1ns/1ps
package nbs_pkg;

  // Walker states; S_DRAIN absorbs a read left in flight by a restart.
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_DRAIN = 3'd1,
    S_ISSUE = 3'd2,
    S_WAIT  = 3'd3,
    S_DONE  = 3'd4
  } scan_state_e;

  // Value of an untouched (erased) marker byte.
  localparam logic [7:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/nbs_walker.sv
`timescale 1ns/1ps
module nbs_walker
  import nbs_pkg::*;
#(
  parameter int NUM_BLOCKS      = 4096,
  parameter int PAGES_PER_BLOCK = 32,
  parameter int BLK_W           = 12,
  parameter int ROW_W           = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             rd_valid_i,
  input  logic [7:0]       rd_data_i,
  output logic             rd_req_o,
  output logic [ROW_W-1:0] rd_page_o,
  output logic             tbl_clr_o,
  output logic             tbl_we_o,
  output logic [BLK_W-1:0] tbl_idx_o,
  output logic             tbl_bad_o,
  output logic             done_o
);

  localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);
  localparam bit PAGES_POW2 = ((PAGES_PER_BLOCK & (PAGES_PER_BLOCK - 1)) == 0);
  localparam int PG_W = (PAGES_PER_BLOCK > 1) ? $clog2(PAGES_PER_BLOCK) : 1;

  scan_state_e      st_q, st_d;
  logic [BLK_W-1:0] blk_q, blk_d;
  logic             sel_q, sel_d;     // 0: first page, 1: second page
  logic             pend_q, pend_d;   // a read is in flight
  logic             marker_hit;

  // Next-state logic
  always_comb begin
    st_d       = st_q;
    blk_d      = blk_q;
    sel_d      = sel_q;
    pend_d     = pend_q;
    tbl_clr_o  = 1'b0;
    tbl_we_o   = 1'b0;
    tbl_bad_o  = 1'b0;
    marker_hit = (rd_data_i != ERASED_BYTE);

    // In-flight tracking runs regardless of restarts (R10)
    if (st_q == S_ISSUE)  pend_d = 1'b1;
    else if (rd_valid_i)  pend_d = 1'b0;

    if (start_i) begin
      tbl_clr_o = 1'b1;
      st_d      = S_DRAIN;
      blk_d     = '0;
      sel_d     = 1'b0;
    end else begin
      unique case (st_q)
        S_DRAIN: if (!pend_q || rd_valid_i) st_d = S_ISSUE;
        S_ISSUE: st_d = S_WAIT;
        S_WAIT: begin
          if (rd_valid_i) begin
            if (!marker_hit && !sel_q) begin
              sel_d = 1'b1;
              st_d  = S_ISSUE;
            end else begin
              // Verdict: early on a first-page hit (R5), else after page two
              tbl_we_o  = 1'b1;
              tbl_bad_o = marker_hit && (blk_q != '0);   // R7
              if (blk_q == LAST_BLK) begin
                st_d = S_DONE;
              end else begin
                blk_d = blk_q + 1'b1;
                sel_d = 1'b0;
                st_d  = S_ISSUE;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      blk_q  <= '0;
      sel_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      blk_q  <= blk_d;
      sel_q  <= sel_d;
      pend_q <= pend_d;
    end
  end

  assign rd_req_o  = (st_q == S_ISSUE);
  assign tbl_idx_o = blk_q;
  assign done_o    = (st_q == S_DONE);

  // Page address: concatenation for power-of-two block sizes, multiply otherwise
  generate
    if (PAGES_POW2) begin : g_page_cat
      assign rd_page_o = {blk_q, PG_W'(sel_q)};
    end else begin : g_page_mul
      assign rd_page_o = ROW_W'(blk_q) * ROW_W'(PAGES_PER_BLOCK) + ROW_W'(sel_q);
    end
  endgenerate

endmodule

// File: rtl/nbs_bitmap.sv
`timescale 1ns/1ps
module nbs_bitmap #(
  parameter int NUM_BLOCKS = 4096,
  parameter int BLK_W      = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             we_i,
  input  logic [BLK_W-1:0] widx_i,
  input  logic             wbad_i,
  input  logic [BLK_W-1:0] qidx_i,
  output logic             qbad_o
);

  logic [NUM_BLOCKS-1:0] tbl_q, tbl_d;
  logic                  qbad_d;

  always_comb begin
    tbl_d = tbl_q;
    if (clr_i) begin
      tbl_d = '0;
    end else if (we_i && (int'(widx_i) < NUM_BLOCKS)) begin
      tbl_d[widx_i] = wbad_i;
    end
  end

  // Lookup samples the pre-edge contents (R9)
  always_comb begin
    qbad_d = 1'b0;
    if (int'(qidx_i) < NUM_BLOCKS) qbad_d = tbl_q[qidx_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_q  <= '0;
      qbad_o <= 1'b0;
    end else begin
      tbl_q  <= tbl_d;
      qbad_o <= qbad_d;
    end
  end

endmodule

// File: rtl/nbs_tally.sv
`timescale 1ns/1ps
module nbs_tally #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = count_o;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = count_o + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_o <= '0;
    else        count_o <= cnt_d;
  end

endmodule

// File: rtl/blk_mark_scan.sv
`timescale 1ns/1ps
module blk_mark_scan #(
  parameter int NUM_BLOCKS      = 4096,
  parameter int PAGES_PER_BLOCK = 32,
  parameter int MARK_OFFSET     = 5,
  parameter int COL_W           = 9,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int ROW_W = $clog2(NUM_BLOCKS * PAGES_PER_BLOCK),
  localparam int CNT_W = $clog2(NUM_BLOCKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             rd_req_o,
  output logic [ROW_W-1:0] rd_page_o,
  output logic             rd_spare_o,
  output logic [COL_W-1:0] rd_col_o,
  input  logic             rd_valid_i,
  input  logic [7:0]       rd_data_i,
  output logic             done_o,
  output logic [CNT_W-1:0] bad_count_o,
  input  logic [BLK_W-1:0] q_addr_i,
  output logic             q_bad_o
);

  logic             tbl_clr;
  logic             tbl_we;
  logic [BLK_W-1:0] tbl_idx;
  logic             tbl_bad;

  nbs_walker #(
    .NUM_BLOCKS      (NUM_BLOCKS),
    .PAGES_PER_BLOCK (PAGES_PER_BLOCK),
    .BLK_W           (BLK_W),
    .ROW_W           (ROW_W)
  ) u_walker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .rd_valid_i (rd_valid_i),
    .rd_data_i  (rd_data_i),
    .rd_req_o   (rd_req_o),
    .rd_page_o  (rd_page_o),
    .tbl_clr_o  (tbl_clr),
    .tbl_we_o   (tbl_we),
    .tbl_idx_o  (tbl_idx),
    .tbl_bad_o  (tbl_bad),
    .done_o     (done_o)
  );

  nbs_bitmap #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .BLK_W      (BLK_W)
  ) u_bitmap (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (tbl_clr),
    .we_i   (tbl_we),
    .widx_i (tbl_idx),
    .wbad_i (tbl_bad),
    .qidx_i (q_addr_i),
    .qbad_o (q_bad_o)
  );

  nbs_tally #(
    .CNT_W (CNT_W)
  ) u_tally (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (tbl_clr),
    .inc_i   (tbl_we && tbl_bad),
    .count_o (bad_count_o)
  );

  // Marker lives in the spare area at a fixed offset (R3)
  assign rd_spare_o = 1'b1;
  assign rd_col_o   = COL_W'(MARK_OFFSET);

endmodule

// File: rtl/nbs_checker.sv
`timescale 1ns/1ps
module nbs_checker #(
  parameter int NUM_BLOCKS      = 4096,
  parameter int PAGES_PER_BLOCK = 32,
  parameter int MARK_OFFSET     = 5,
  parameter int COL_W           = 9,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int ROW_W = $clog2(NUM_BLOCKS * PAGES_PER_BLOCK),
  localparam int CNT_W = $clog2(NUM_BLOCKS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             rd_req_o,
  input logic [ROW_W-1:0] rd_page_o,
  input logic             rd_spare_o,
  input logic [COL_W-1:0] rd_col_o,
  input logic             rd_valid_i,
  input logic             done_o,
  input logic [CNT_W-1:0] bad_count_o,
  input logic [BLK_W-1:0] q_addr_i,
  input logic             q_bad_o
);

  logic in_flight;
  logic q_zero_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_flight <= 1'b0;
      q_zero_d  <= 1'b0;
    end else begin
      if (rd_req_o)        in_flight <= 1'b1;
      else if (rd_valid_i) in_flight <= 1'b0;
      q_zero_d <= (q_addr_i == '0);
    end
  end

  p_single_flight_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> !in_flight);

  p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |=> !rd_req_o);

  p_spare_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> (rd_spare_o && rd_col_o == COL_W'(MARK_OFFSET)));

  p_first_two_pages_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> ((rd_page_o % ROW_W'(PAGES_PER_BLOCK)) < ROW_W'(2)));

  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!done_o && bad_count_o == '0 && !rd_req_o));

  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(bad_count_o)));

  p_quiet_when_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !rd_req_o);

  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (bad_count_o == $past(bad_count_o) ||
                  bad_count_o == $past(bad_count_o) + CNT_W'(1)));

  p_block0_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    q_zero_d |-> !q_bad_o);

endmodule

bind blk_mark_scan nbs_checker #(
  .NUM_BLOCKS      (NUM_BLOCKS),
  .PAGES_PER_BLOCK (PAGES_PER_BLOCK),
  .MARK_OFFSET     (MARK_OFFSET),
  .COL_W           (COL_W)
) u_nbs_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .rd_req_o    (rd_req_o),
  .rd_page_o   (rd_page_o),
  .rd_spare_o  (rd_spare_o),
  .rd_col_o    (rd_col_o),
  .rd_valid_i  (rd_valid_i),
  .done_o      (done_o),
  .bad_count_o (bad_count_o),
  .q_addr_i    (q_addr_i),
  .q_bad_o     (q_bad_o)
);

// File: tb/test_blk_mark_scan.sv
`timescale 1ns/1ps
module test_blk_mark_scan;

  localparam int NB = 4096;
  localparam int PG = 32;
  localparam int WD_LIMIT = 190000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic        rd_req_o;
  logic [16:0] rd_page_o;
  logic        rd_spare_o;
  logic [8:0]  rd_col_o;
  logic        rd_valid_i;
  logic [7:0]  rd_data_i;
  logic        done_o;
  logic [12:0] bad_count_o;
  logic [11:0] q_addr_i;
  logic        q_bad_o;

  always #10 clk = ~clk;   // 50 MHz

  blk_mark_scan i_blk_mark_scan (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .rd_req_o    (rd_req_o),
    .rd_page_o   (rd_page_o),
    .rd_spare_o  (rd_spare_o),
    .rd_col_o    (rd_col_o),
    .rd_valid_i  (rd_valid_i),
    .rd_data_i   (rd_data_i),
    .done_o      (done_o),
    .bad_count_o (bad_count_o),
    .q_addr_i    (q_addr_i),
    .q_bad_o     (q_bad_o)
  );

  // Flash image: marker bytes of page 0 and page 1 per block
  logic [7:0] m0 [NB];
  logic [7:0] m1 [NB];

  // Reference model state
  bit [NB-1:0] exp_tbl;
  int    checks = 0, fails = 0, cyc = 0;
  bit    wd = 0, phase0 = 0;
  int    req_in = -1;          // steps until the next expected request
  int    exp_page = 0, pend_page = 0, lat = 0, cur_blk = 0;
  int    m_cnt = 0, sweep_idx = 0, abort_mode = 0;
  bit    m_done = 0, outstanding = 0, just = 0, discard = 0;
  bit    start_req = 0, sweep = 0, skip_tag = 0, abort_tag = 0;
  bit    q_exp = 0;
  string q_tag = "R1";

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic void fill(input int set);
    for (int b = 0; b < NB; b++) begin
      if (set == 1) begin
        m0[b] = (b % 37 == 5)  ? 8'h00 : 8'hFF;
        m1[b] = (b % 53 == 7)  ? 8'hA5 : 8'hFF;
      end else begin
        m0[b] = (b % 41 == 3)  ? 8'hFE : 8'hFF;
        m1[b] = (b % 29 == 11) ? 8'h7F : 8'hFF;
      end
    end
    m0[0] = 8'h00;   // block 0 carries a stray marker; must still read valid
    m1[0] = 8'h12;
  endfunction

  function automatic logic [7:0] flash_byte(input int page);
    return (page % PG == 0) ? m0[page / PG] : m1[page / PG];
  endfunction

  function automatic int lat_of(input int page);
    return ((page >> 1) ^ (page * 5)) & 3;
  endfunction

  task automatic step();
    bit drv, go, hit;
    int b;
    logic [7:0] d;
    string tg;
    if (wd) return;
    @(negedge clk);
    cyc++;
    if (cyc > WD_LIMIT) begin wd = 1; return; end
    if (req_in > 0) req_in--;

    // Compare outputs against the model
    chk(rd_req_o == (req_in == 0), phase0 ? "R1" : "R3", rd_req_o, req_in == 0);
    if (req_in == 0) begin
      if (abort_tag)           tg = "R10";
      else if (exp_page == 0)  tg = "R2";
      else if (skip_tag)       tg = "R5";
      else                     tg = "R4";
      chk(rd_page_o == 17'(exp_page), tg, rd_page_o, exp_page);
      chk(rd_spare_o == 1'b1 && rd_col_o == 9'd5, "R3",
          {rd_spare_o, rd_col_o}, {1'b1, 9'd5});
      abort_tag   = 0;
      outstanding = 1;
      just        = 1;
      pend_page   = exp_page;
      lat         = lat_of(exp_page);
      req_in      = -1;
    end
    chk(done_o == m_done, phase0 ? "R1" : "R8", done_o, m_done);
    chk(bad_count_o == 13'(m_cnt), phase0 ? "R1" : "R8", bad_count_o, m_cnt);
    chk(q_bad_o == q_exp, q_tag, q_bad_o, q_exp);

    // Drive inputs for the coming edge
    start_i    = 1'b0;
    rd_valid_i = 1'b0;
    rd_data_i  = 8'h00;
    q_addr_i   = sweep ? 12'(sweep_idx) : 12'(cur_blk);
    q_exp      = exp_tbl[q_addr_i];
    q_tag      = phase0 ? "R1" : (q_addr_i == 0) ? "R7" : sweep ? "R6" : "R9";

    drv = 0;
    if (outstanding && !just) begin
      if (lat == 0) begin
        drv        = 1;
        d          = flash_byte(pend_page);
        rd_valid_i = 1'b1;
        rd_data_i  = d;
        outstanding = 0;
      end else begin
        lat--;
      end
    end
    just = 0;

    go = start_req ||
         (abort_mode == 1 && drv && cur_blk >= 700) ||
         (abort_mode == 2 && outstanding && lat > 0 && cur_blk >= 1500);

    if (go) begin
      // R2/R10: restart; any answer driven now is discarded
      if (!start_req) begin abort_mode++; abort_tag = 1; end
      start_req = 0;
      start_i   = 1'b1;
      m_done    = 0;
      m_cnt     = 0;
      exp_tbl   = '0;
      exp_page  = 0;
      cur_blk   = 0;
      skip_tag  = 0;
      discard   = 0;
      if (outstanding) begin discard = 1; req_in = -1; end
      else             req_in = 2;
    end else if (drv) begin
      if (discard) begin
        discard = 0;
        req_in  = 1;
      end else begin
        b   = pend_page / PG;
        hit = (d != 8'hFF);
        if (!hit && (pend_page % PG == 0)) begin
          exp_page = pend_page + 1;
          req_in   = 1;
          skip_tag = 0;
        end else begin
          if (hit && b != 0) begin exp_tbl[b] = 1'b1; m_cnt++; end
          skip_tag = hit && (pend_page % PG == 0);
          if (b == NB - 1) m_done = 1;
          else begin
            exp_page = (b + 1) * PG;
            cur_blk  = b + 1;
            req_in   = 1;
          end
        end
      end
    end
  endtask

  task automatic run_scan();
    start_req = 1;
    step();
    while (!m_done && !wd) step();
  endtask

  task automatic do_sweep();
    sweep = 1;
    for (int i = 0; i < NB; i++) begin
      sweep_idx = i;
      step();
    end
    step();            // observe the last lookup
    sweep = 0;
  endtask

  initial begin
    rst_n      = 1'b0;
    start_i    = 1'b0;
    rd_valid_i = 1'b0;
    rd_data_i  = 8'h00;
    q_addr_i   = '0;
    exp_tbl    = '0;
    fill(1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state and no activity without a start
    phase0 = 1;
    repeat (4) step();
    phase0 = 0;
    repeat (3) step();

    // First pass, then read the whole table back (R6, R7, R9)
    run_scan();
    repeat (5) step();
    do_sweep();

    // Second pass on a changed image with two restarts (R10) and full readback
    fill(2);
    abort_mode = 1;
    run_scan();
    repeat (5) step();
    do_sweep();

    if (wd) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule